// File: doc/BRIEF.md
# Display Controller Host Command Port

This block is the host-facing front end of a graphic display controller. A host drives an 8-bit bidirectional bus together with a chip enable, a select strobe, a read/write line and a data/command line. Each falling edge of the strobe that arrives while the enable is high is one bus access. The block samples the strobe in its own clock domain. In a command access, the byte is decoded into configuration registers. In a data access, the display RAM is read or written at the current page and column pointer.

The decoded configuration covers contrast, the icon drive level, the vertical scroll offset and a 32-entry vector of single-bit flags. These values are plain register outputs for the analog and scan logic that sit next to the block. The block also keeps the RAM pointer. It can save and restore the column, and it runs a two-step clear: a command arms the clear, and the next data write fires it. The block drives the shared bus only during a read access, returning either RAM data or the contrast value.

Top module: `disp_host_port`

## Requirements
- R1: An access takes effect only on a falling edge of `bus_strb` while `bus_en` is high. With `bus_en` low, no RAM strobe is raised and no register or pointer changes.
- R2: A command byte with bit 7 set loads the column pointer from bits 6..0. A value above 0x77 loads column 0.
- R3: A command byte 00000ppp with ppp in 0..4 loads the page pointer (0 = first page, 4 = icon page). The values 5..7 leave the page unchanged.
- R4: Each data write raises `ram_we` and each data read raises `ram_re` for one clock, at the current page and column. The column then advances by one and wraps from 119 to 0. Command accesses never advance it.
- R5: Command 0x35 stores the column pointer. Command 0x34 copies the stored value back into the column pointer. The stored value resets to 0.
- R6: Command 0x36 arms the main-area clear and 0x37 arms the icon-page clear. The next data write raises `ram_clr_main` or `ram_clr_icon` in place of `ram_we`, does not advance the column, and disarms the clear.
- R7: Command 0001cccc loads the 4-bit contrast value. Contrast resets to 0.
- R8: Command 0x71 adds one to the contrast value and 0x70 subtracts one, wrapping modulo 16.
- R9: During a read access (`bus_en` and `bus_rd` high), the block drives `bus_d`. In a data read it drives `ram_rdata`; in a command read it drives 0001 on bits 7..4 and the contrast value on bits 3..0. At all other times `bus_d` is high impedance.
- R10: A command byte with bits 7..5 equal to 001 or 011 (other than 0x34..0x37 and 0x70/0x71) writes bit 0 into flag number {b6,b4,b3,b2,b1}. Flag 4 is display enable, flag 20 is the 1/16 duty select and flag 12 is the 1/5 bias select. All flags reset to 0, and flag 3 is reserved: commands 0x26/0x27 change nothing.
- R11: Command 010sssss loads the 5-bit scroll offset (reset 0). Command 000011ll loads the 2-bit icon level, which resets to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Chip enable, high to accept accesses |
| bus_strb | input | 1 | Select strobe, falling edge marks an access |
| bus_rd | input | 1 | High for read, low for write |
| bus_dc | input | 1 | High for display data, low for command |
| bus_d | inout | 8 | Shared data bus |
| ram_rdata | input | 8 | Read data from display RAM at the current pointer |
| ram_page | output | 3 | Current page pointer |
| ram_col | output | 7 | Current column pointer |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_clr_main | output | 1 | Clear strobe for pages 0..3 |
| ram_clr_icon | output | 1 | Clear strobe for the icon page |
| cfg_contrast | output | 4 | Contrast level |
| cfg_icon_lvl | output | 2 | Icon drive level |
| cfg_scroll | output | 5 | Vertical scroll offset |
| cfg_flags | output | 32 | Single-bit configuration flags |

## Verification
A wrong column or page pointer shows on `ram_col`/`ram_page` with the very next data strobe, so every pointer test ends with a data write whose address is checked. A clear that stays armed, or one lost too early, shows on that same write as a missing `ram_we` or a missing clear strobe. Register faults appear at once on the `cfg_*` outputs, and the contrast path is also checked end to end through a command read on the bus. The wrap points (column 119, contrast 15 and 0) and the reserved codes are driven on purpose, because an off-by-one there would otherwise stay hidden.

// File: rtl/disp_host_pkg.sv
package disp_host_pkg;

  typedef enum logic [3:0] {
    K_NONE,
    K_COL,
    K_PAGE,
    K_CONTRAST,
    K_STEP,
    K_ICONLVL,
    K_SCROLL,
    K_FLAG,
    K_SAVE,
    K_RESTORE,
    K_CLR_MAIN,
    K_CLR_ICON
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e   kind;
    logic [6:0]  arg;
    logic [4:0]  fidx;
  } cmd_t;

  // flag-space slots taken by other commands
  localparam logic [4:0] FIDX_RSVD = 5'd3;
  localparam logic [4:0] FIDX_SAVE = 5'd10;
  localparam logic [4:0] FIDX_CLR  = 5'd11;
  localparam logic [4:0] FIDX_STEP = 5'd24;

endpackage

// File: rtl/dhp_strobe_edge.sv
module dhp_strobe_edge (
  input  logic clk,
  input  logic rst_ni,
  input  logic strb_i,
  output logic fall_o
);
  logic strb_q;
  logic strb_d;

  always_comb strb_d = strb_i;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) strb_q <= 1'b0;
    else         strb_q <= strb_d;
  end

  assign fall_o = strb_q & ~strb_i;
endmodule

// File: rtl/dhp_cmd_decode.sv
module dhp_cmd_decode
  import disp_host_pkg::*;
#(
  parameter int NUM_PAGES = 5
) (
  input  logic [7:0] byte_i,
  output cmd_t       cmd_o
);
  logic [4:0] fidx;

  always_comb begin
    fidx        = {byte_i[6], byte_i[4:1]};
    cmd_o.arg   = byte_i[6:0];
    cmd_o.fidx  = fidx;
    cmd_o.kind  = K_NONE;
    if (byte_i[7]) begin
      cmd_o.kind = K_COL;
    end else if (byte_i[6:5] == 2'b10) begin
      cmd_o.kind = K_SCROLL;
    end else if (byte_i[5]) begin
      // prefixes 001 and 011
      if (fidx == FIDX_SAVE)      cmd_o.kind = byte_i[0] ? K_SAVE : K_RESTORE;
      else if (fidx == FIDX_CLR)  cmd_o.kind = byte_i[0] ? K_CLR_ICON : K_CLR_MAIN;
      else if (fidx == FIDX_STEP) cmd_o.kind = K_STEP;
      else if (fidx == FIDX_RSVD) cmd_o.kind = K_NONE;
      else                        cmd_o.kind = K_FLAG;
    end else if (byte_i[4]) begin
      cmd_o.kind = K_CONTRAST;
    end else if (byte_i[3:2] == 2'b11) begin
      cmd_o.kind = K_ICONLVL;
    end else if (byte_i[3] == 1'b0) begin
      if (int'(byte_i[2:0]) < NUM_PAGES) cmd_o.kind = K_PAGE;
    end
  end
endmodule

// File: rtl/dhp_addr_ptr.sv
module dhp_addr_ptr
  import disp_host_pkg::*;
#(
  parameter int NUM_COLS  = 120,
  parameter int NUM_PAGES = 5
) (
  input  logic                         clk,
  input  logic                         rst_ni,
  input  cmd_t                         cmd_i,
  input  logic                         cmd_wr_i,
  input  logic                         dat_wr_i,
  input  logic                         dat_rd_i,
  output logic [$clog2(NUM_PAGES)-1:0] page_o,
  output logic [$clog2(NUM_COLS)-1:0]  col_o,
  output logic                         we_o,
  output logic                         re_o,
  output logic                         clr_main_o,
  output logic                         clr_icon_o
);
  localparam int COL_W  = $clog2(NUM_COLS);
  localparam int PAGE_W = $clog2(NUM_PAGES);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);
  localparam logic [6:0]       LAST_ARG = 7'(NUM_COLS - 1);

  logic [PAGE_W-1:0] page_q, page_d;
  logic [COL_W-1:0]  col_q, col_d, save_q, save_d, col_inc;
  logic              pend_main_q, pend_main_d, pend_icon_q, pend_icon_d;
  logic              pend_any;

  always_comb begin
    pend_any   = pend_main_q | pend_icon_q;
    col_inc    = (col_q == LAST_COL) ? '0 : col_q + 1'b1;
    we_o       = dat_wr_i & ~pend_any;
    re_o       = dat_rd_i;
    clr_main_o = dat_wr_i & pend_main_q;
    clr_icon_o = dat_wr_i & pend_icon_q;
  end

  always_comb begin
    page_d      = page_q;
    col_d       = col_q;
    save_d      = save_q;
    pend_main_d = pend_main_q;
    pend_icon_d = pend_icon_q;
    if (cmd_wr_i) begin
      unique case (cmd_i.kind)
        K_COL:      col_d = (cmd_i.arg > LAST_ARG) ? '0 : cmd_i.arg[COL_W-1:0];
        K_PAGE:     page_d = cmd_i.arg[PAGE_W-1:0];
        K_SAVE:     save_d = col_q;
        K_RESTORE:  col_d = save_q;
        K_CLR_MAIN: pend_main_d = 1'b1;
        K_CLR_ICON: pend_icon_d = 1'b1;
        default:    ;
      endcase
    end
    if (we_o || re_o) col_d = col_inc;
    if (dat_wr_i && pend_any) begin
      pend_main_d = 1'b0;
      pend_icon_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q      <= '0;
      col_q       <= '0;
      save_q      <= '0;
      pend_main_q <= 1'b0;
      pend_icon_q <= 1'b0;
    end else begin
      page_q      <= page_d;
      col_q       <= col_d;
      save_q      <= save_d;
      pend_main_q <= pend_main_d;
      pend_icon_q <= pend_icon_d;
    end
  end

  assign page_o = page_q;
  assign col_o  = col_q;

  // R2: column pointer never leaves the RAM width
  a_r2_col_in_range: assert property (@(posedge clk) disable iff (!rst_ni)
    col_q <= LAST_COL);
  // R3: page pointer never leaves the page range
  a_r3_page_in_range: assert property (@(posedge clk) disable iff (!rst_ni)
    int'(page_q) < NUM_PAGES);
  // R4: data access advances the column with wrap
  a_r4_col_advance: assert property (@(posedge clk) disable iff (!rst_ni)
    (we_o || re_o) |=> col_q == (($past(col_q) == LAST_COL) ? '0 : $past(col_q) + 1'b1));
  // R6: a dummy write keeps the column and disarms the clear
  a_r6_dummy_holds_col: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_main_o || clr_icon_o) |=> (col_q == $past(col_q)) && !pend_main_q && !pend_icon_q);
endmodule

// File: rtl/dhp_cfg_regs.sv
module dhp_cfg_regs
  import disp_host_pkg::*;
#(
  parameter logic [31:0] FLAG_POR = '0,
  parameter logic [1:0]  ICON_POR = 2'b10
) (
  input  logic        clk,
  input  logic        rst_ni,
  input  cmd_t        cmd_i,
  input  logic        cmd_wr_i,
  output logic [3:0]  contrast_o,
  output logic [1:0]  icon_o,
  output logic [4:0]  scroll_o,
  output logic [31:0] flags_o
);
  logic [3:0]  contrast_q, contrast_d;
  logic [1:0]  icon_q, icon_d;
  logic [4:0]  scroll_q, scroll_d;
  logic [31:0] flags_q, flags_d;

  always_comb begin
    contrast_d = contrast_q;
    icon_d     = icon_q;
    scroll_d   = scroll_q;
    flags_d    = flags_q;
    if (cmd_wr_i) begin
      unique case (cmd_i.kind)
        K_CONTRAST: contrast_d = cmd_i.arg[3:0];
        K_STEP:     contrast_d = cmd_i.arg[0] ? contrast_q + 4'd1 : contrast_q - 4'd1;
        K_ICONLVL:  icon_d = cmd_i.arg[1:0];
        K_SCROLL:   scroll_d = cmd_i.arg[4:0];
        K_FLAG:     flags_d[cmd_i.fidx] = cmd_i.arg[0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      contrast_q <= '0;
      icon_q     <= ICON_POR;
      scroll_q   <= '0;
      flags_q    <= FLAG_POR;
    end else begin
      contrast_q <= contrast_d;
      icon_q     <= icon_d;
      scroll_q   <= scroll_d;
      flags_q    <= flags_d;
    end
  end

  assign contrast_o = contrast_q;
  assign icon_o     = icon_q;
  assign scroll_o   = scroll_q;
  assign flags_o    = flags_q;

  // R7: contrast only moves on a command write
  a_r7_contrast_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !cmd_wr_i |=> contrast_q == $past(contrast_q));
  // R8: step up wraps modulo 16
  a_r8_step_up: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_wr_i && cmd_i.kind == K_STEP && cmd_i.arg[0]) |=> contrast_q == $past(contrast_q) + 4'd1);
  // R10: one flag command touches at most one flag
  a_r10_one_flag: assert property (@(posedge clk) disable iff (!rst_ni)
    cmd_wr_i |=> $countones(flags_q ^ $past(flags_q)) <= 1);
endmodule

// File: rtl/disp_host_port.sv
module disp_host_port
  import disp_host_pkg::*;
#(
  parameter int          NUM_COLS  = 120,
  parameter int          NUM_PAGES = 5,
  parameter logic [31:0] FLAG_POR  = '0,
  parameter logic [1:0]  ICON_POR  = 2'b10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_strb,
  input  logic        bus_rd,
  input  logic        bus_dc,
  inout  wire  [7:0]  bus_d,
  input  logic [7:0]  ram_rdata,
  output logic [2:0]  ram_page,
  output logic [6:0]  ram_col,
  output logic        ram_we,
  output logic        ram_re,
  output logic [7:0]  ram_wdata,
  output logic        ram_clr_main,
  output logic        ram_clr_icon,
  output logic [3:0]  cfg_contrast,
  output logic [1:0]  cfg_icon_lvl,
  output logic [4:0]  cfg_scroll,
  output logic [31:0] cfg_flags
);
  localparam int COL_W  = $clog2(NUM_COLS);
  localparam int PAGE_W = $clog2(NUM_PAGES);

  logic rst_meta, rst_ni;
  logic fall, acc, cmd_wr, dat_wr, dat_rd, drive;
  logic [7:0] din, dout;
  logic [PAGE_W-1:0] page;
  logic [COL_W-1:0]  col;
  cmd_t cmd;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  dhp_strobe_edge u_edge (
    .clk    (clk),
    .rst_ni (rst_ni),
    .strb_i (bus_strb),
    .fall_o (fall)
  );

  assign din    = bus_d;
  assign acc    = fall & bus_en;
  assign cmd_wr = acc & ~bus_rd & ~bus_dc;
  assign dat_wr = acc & ~bus_rd & bus_dc;
  assign dat_rd = acc & bus_rd & bus_dc;

  dhp_cmd_decode #(.NUM_PAGES(NUM_PAGES)) u_dec (
    .byte_i (din),
    .cmd_o  (cmd)
  );

  dhp_addr_ptr #(.NUM_COLS(NUM_COLS), .NUM_PAGES(NUM_PAGES)) u_ptr (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .cmd_wr_i   (cmd_wr),
    .dat_wr_i   (dat_wr),
    .dat_rd_i   (dat_rd),
    .page_o     (page),
    .col_o      (col),
    .we_o       (ram_we),
    .re_o       (ram_re),
    .clr_main_o (ram_clr_main),
    .clr_icon_o (ram_clr_icon)
  );

  dhp_cfg_regs #(.FLAG_POR(FLAG_POR), .ICON_POR(ICON_POR)) u_cfg (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .cmd_wr_i   (cmd_wr),
    .contrast_o (cfg_contrast),
    .icon_o     (cfg_icon_lvl),
    .scroll_o   (cfg_scroll),
    .flags_o    (cfg_flags)
  );

  assign ram_page  = 3'(page);
  assign ram_col   = 7'(col);
  assign ram_wdata = din;

  assign drive = bus_en & bus_rd;
  assign dout  = bus_dc ? ram_rdata : {4'b0001, cfg_contrast};
  assign bus_d = drive ? dout : 8'bz;

  // R1: no RAM strobe of any kind while the chip is not enabled
  a_r1_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_ni)
    !bus_en |-> !(ram_we || ram_re || ram_clr_main || ram_clr_icon));
  // R4: write and read strobes never coincide
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({ram_we, ram_re, ram_clr_main | ram_clr_icon}));
endmodule

// File: tb/disp_host_port_bench.sv
module disp_host_port_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_en, bus_strb, bus_rd, bus_dc;
  logic tb_oe;
  logic [7:0] tb_drv, ram_rdata;
  wire  [7:0] bus_d;
  logic [2:0] ram_page;
  logic [6:0] ram_col;
  logic ram_we, ram_re, ram_clr_main, ram_clr_icon;
  logic [7:0] ram_wdata;
  logic [3:0] cfg_contrast;
  logic [1:0] cfg_icon_lvl;
  logic [4:0] cfg_scroll;
  logic [31:0] cfg_flags;

  int n_checks = 0;
  int n_err = 0;

  logic c_we, c_re, c_cm, c_ci;
  logic [6:0] c_col;
  logic [2:0] c_page;
  logic [7:0] c_bus, c_wdata;

  assign bus_d = tb_oe ? tb_drv : 8'bz;

  always #5 clk = ~clk;

  disp_host_port u_disp_host_port (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_strb(bus_strb),
    .bus_rd(bus_rd), .bus_dc(bus_dc), .bus_d(bus_d), .ram_rdata(ram_rdata),
    .ram_page(ram_page), .ram_col(ram_col), .ram_we(ram_we), .ram_re(ram_re),
    .ram_wdata(ram_wdata), .ram_clr_main(ram_clr_main), .ram_clr_icon(ram_clr_icon),
    .cfg_contrast(cfg_contrast), .cfg_icon_lvl(cfg_icon_lvl),
    .cfg_scroll(cfg_scroll), .cfg_flags(cfg_flags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bus access; captures the outputs while the strobe is low
  task automatic cycle(input logic en, input logic rd, input logic dc, input logic [7:0] d);
    @(negedge clk);
    bus_en = en; bus_rd = rd; bus_dc = dc; tb_drv = d; tb_oe = ~rd; bus_strb = 1'b1;
    @(negedge clk);
    bus_strb = 1'b0;
    #1;
    c_we = ram_we; c_re = ram_re; c_cm = ram_clr_main; c_ci = ram_clr_icon;
    c_col = ram_col; c_page = ram_page; c_bus = bus_d; c_wdata = ram_wdata;
    @(negedge clk);
    bus_strb = 1'b1; tb_oe = 1'b0; bus_en = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b); cycle(1'b1, 1'b0, 1'b0, b); endtask
  task automatic wr(input logic [7:0] b);  cycle(1'b1, 1'b0, 1'b1, b); endtask

  task automatic t_reset;
    check("R7 contrast reset", 32'(cfg_contrast), 32'h0);
    check("R10 flags reset", cfg_flags, 32'h0);
    check("R11 icon level reset", 32'(cfg_icon_lvl), 32'h2);
    check("R11 scroll reset", 32'(cfg_scroll), 32'h0);
    check("R9 bus idle high-z", {24'h0, bus_d}, {24'h0, 8'bz});
    wr(8'h11);
    check("R4 first write strobe", 32'(c_we), 32'h1);
    check("R4 first write address", {c_page, c_col}, 32'h0);
    check("R4 write data", 32'(c_wdata), 32'h11);
  endtask

  task automatic t_column;
    cmd(8'h85); wr(8'h00);
    check("R2 column load", 32'(c_col), 32'd5);
    wr(8'h00);
    check("R4 column advance", 32'(c_col), 32'd6);
    cmd(8'hF7); wr(8'h00);
    check("R2 column 0x77", 32'(c_col), 32'd119);
    wr(8'h00);
    check("R4 column wrap", 32'(c_col), 32'd0);
    cmd(8'hFA); wr(8'h00);
    check("R2 column over range", 32'(c_col), 32'd0);
    cmd(8'h8A); cmd(8'h13); wr(8'h00);
    check("R4 command no advance", 32'(c_col), 32'd10);
  endtask

  task automatic t_page;
    cmd(8'h04); wr(8'h00);
    check("R3 page 4", 32'(c_page), 32'd4);
    cmd(8'h06); wr(8'h00);
    check("R3 reserved page", 32'(c_page), 32'd4);
    cmd(8'h02); wr(8'h00);
    check("R3 page 2", 32'(c_page), 32'd2);
  endtask

  task automatic t_enable;
    cmd(8'h90);
    cycle(1'b0, 1'b0, 1'b1, 8'h55);
    check("R1 disabled no strobe", {28'h0, c_we, c_re, c_cm, c_ci}, 32'h0);
    cycle(1'b0, 1'b0, 1'b0, 8'h1F);
    check("R1 disabled no register", 32'(cfg_contrast), 32'h3);
    wr(8'h00);
    check("R1 disabled no advance", 32'(c_col), 32'h10);
  endtask

  task automatic t_read;
    ram_rdata = 8'hA5;
    cmd(8'h94);
    cycle(1'b1, 1'b1, 1'b1, 8'h00);
    check("R4 read strobe", {30'h0, c_re, c_we}, 32'h2);
    check("R4 read address", 32'(c_col), 32'd20);
    check("R9 data read on bus", 32'(c_bus), 32'hA5);
    cycle(1'b1, 1'b1, 1'b1, 8'h00);
    check("R4 read advance", 32'(c_col), 32'd21);
    @(negedge clk); bus_en = 1'b1; bus_rd = 1'b0; #1;
    check("R9 write cycle high-z", {24'h0, bus_d}, {24'h0, 8'bz});
    bus_en = 1'b0;
  endtask

  task automatic t_save;
    cmd(8'h9E); cmd(8'h35); cmd(8'hA8); cmd(8'h34); wr(8'h00);
    check("R5 restore column", 32'(c_col), 32'd30);
  endtask

  task automatic t_clear;
    cmd(8'hC0); cmd(8'h36); wr(8'hFF);
    check("R6 main clear strobe", {29'h0, c_we, c_cm, c_ci}, 32'h2);
    check("R6 dummy address", 32'(c_col), 32'd64);
    wr(8'h01);
    check("R6 no advance then write", {31'h0, c_we}, 32'h1);
    check("R6 column after dummy", 32'(c_col), 32'd64);
    cmd(8'h37); wr(8'hFF);
    check("R6 icon clear strobe", {29'h0, c_we, c_cm, c_ci}, 32'h1);
  endtask

  task automatic t_contrast;
    cmd(8'h1C);
    check("R7 contrast load", 32'(cfg_contrast), 32'd12);
    cycle(1'b1, 1'b1, 1'b0, 8'h00);
    check("R9 contrast readback", 32'(c_bus), 32'h1C);
    cmd(8'h71);
    check("R8 contrast up", 32'(cfg_contrast), 32'd13);
    cmd(8'h1F); cmd(8'h71);
    check("R8 contrast wrap up", 32'(cfg_contrast), 32'd0);
    cmd(8'h70);
    check("R8 contrast wrap down", 32'(cfg_contrast), 32'd15);
  endtask

  task automatic t_flags;
    cmd(8'h29);
    check("R10 display flag", cfg_flags, 32'h0000_0010);
    cmd(8'h69); cmd(8'h39);
    check("R10 duty and bias flags", cfg_flags, 32'h0010_1010);
    cmd(8'h28);
    check("R10 display off", cfg_flags, 32'h0010_1000);
    cmd(8'h27);
    check("R10 reserved code ignored", cfg_flags, 32'h0010_1000);
  endtask

  task automatic t_scroll_icon;
    cmd(8'h53);
    check("R11 scroll load", 32'(cfg_scroll), 32'h13);
    cmd(8'h0D);
    check("R11 icon level load", 32'(cfg_icon_lvl), 32'h1);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_strb = 1'b1; bus_rd = 1'b0; bus_dc = 1'b0;
    tb_oe = 1'b0; tb_drv = 8'h00; ram_rdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_column;
    t_page;
    t_enable;
    t_read;
    t_save;
    t_clear;
    t_contrast;
    t_flags;
    t_scroll_icon;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule